// File: doc/BRIEF.md
# Per-Source Reserved Input Port Buffer

This block sits at the receive side of a router or node port that takes packets from several senders. Arriving packets are split by message class into a request queue and a response queue. Inside each queue, every sender owns a fixed number of reserved slots. A packet whose sender has used up its slots in that class is not stored. Instead, a one-cycle refusal pulse carrying the sender's identity goes out on a dedicated refusal output, which is kept apart from the data path. The port never pushes back on the link, so one busy sender cannot fill the buffer and saturate the network behind it.

The consumer drains the two class queues through separate pop inputs. Each queue presents its oldest packet at its head. Popping a packet releases the slot held by that packet's sender. Responses are accounted for separately from requests, so a sender whose request slots are all in use can still deliver responses, and those responses can still be drained. This keeps the port free of fetch deadlock.

Top module: `srcshare_inport`

## Requirements
- R1: After reset both class queues are empty (`req_valid` and `rsp_valid` low) and `nack_valid` is low.
- R2: A packet presented with `in_valid` high and accepted appears at the head of its class queue on the next cycle, with its source and data unchanged. An `in_cls` value of 0 selects the request queue and 1 selects the response queue.
- R3: Each source holds at most `SLOTS` (default 2) packets per class. A packet that would exceed this is refused and is not stored.
- R4: A refused packet produces `nack_valid` high for exactly one cycle, in the cycle after its `in_valid`, with `nack_src` equal to its source. An accepted packet produces no refusal.
- R5: A source whose share of a class is full does not stop other sources from being accepted into that class.
- R6: A full request share does not affect the response class. The same source's responses are still accepted and can be popped while its requests sit unpopped.
- R7: Each class queue delivers its packets in arrival order, and its head holds steady while it is not popped.
- R8: Popping a packet frees one slot for that packet's source, so a later packet from that source is accepted.
- R9: An accepted packet and a pop of the same source and class in the same cycle leave that source's occupancy unchanged.
- R10: Whether a packet is accepted depends on the occupancy at the start of the cycle. A pop in the same cycle does not make room for a packet from a source whose share is full.
- R11: A pop on an empty queue is ignored. The queue stays empty, and the source slot accounting is not disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Packet present on the input this cycle |
| in_src | input | SRC_W | Source identity of the incoming packet |
| in_cls | input | 1 | Message class: 0 request, 1 response |
| in_data | input | DATA_W | Packet payload |
| nack_valid | output | 1 | One-cycle refusal pulse |
| nack_src | output | SRC_W | Source of the refused packet |
| req_pop | input | 1 | Remove the head of the request queue |
| req_valid | output | 1 | Request queue is not empty |
| req_src | output | SRC_W | Source of the request at the head |
| req_data | output | DATA_W | Payload of the request at the head |
| rsp_pop | input | 1 | Remove the head of the response queue |
| rsp_valid | output | 1 | Response queue is not empty |
| rsp_src | output | SRC_W | Source of the response at the head |
| rsp_data | output | DATA_W | Payload of the response at the head |

## Verification
The bench builds the block with its defaults: four sources, two slots per source and class, and 8-bit payloads. With only two slots, one share fills in two packets, so the refusal on the third packet, the same-cycle pop and accept cases and the start-of-cycle rule can each be reached in a few cycles. Four sources let one sender sit full while its neighbours and its own response share keep working. Queue depth is eight, which is enough to show that packets from different senders keep their arrival order.

// File: rtl/srcshare_pkg.sv
package srcshare_pkg;

    localparam int NUM_CLASSES = 2;

    typedef enum logic {
        CLS_REQ = 1'b0,
        CLS_RSP = 1'b1
    } msg_class_e;

    // Index width with a floor of one bit.
    function automatic int idx_width(input int n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

    // Width of a counter that must reach n.
    function automatic int count_width(input int n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/srcshare_ledger.sv
module srcshare_ledger #(
    parameter int NUM_SRC = 4,
    parameter int SLOTS   = 2,
    parameter int SRC_W   = 2,
    parameter int CNT_W   = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     try_wr,
    input  logic [SRC_W-1:0]         wr_src,
    input  logic                     pop_fire,
    input  logic [SRC_W-1:0]         pop_src,
    output logic                     accept,
    output logic [NUM_SRC*CNT_W-1:0] occ_flat
);

    logic [CNT_W-1:0] occ_sel;

    // Decision uses occupancy held at the start of the cycle.
    assign occ_sel = occ_flat[int'(wr_src)*CNT_W +: CNT_W];
    assign accept  = try_wr && (occ_sel < CNT_W'(SLOTS));

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        logic [CNT_W-1:0] occ_r;
        logic             inc;
        logic             dec;

        assign inc = accept && (wr_src == SRC_W'(i));
        assign dec = pop_fire && (pop_src == SRC_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                occ_r <= '0;
            end else begin
                case ({inc, dec})
                    2'b10:   occ_r <= occ_r + 1'b1;
                    2'b01:   occ_r <= occ_r - 1'b1;
                    default: occ_r <= occ_r;
                endcase
            end
        end

        assign occ_flat[i*CNT_W +: CNT_W] = occ_r;
    end

endmodule

// File: rtl/srcshare_fifo.sv
module srcshare_fifo #(
    parameter int DEPTH = 8,
    parameter int ENT_W = 10,
    parameter int PTR_W = 3,
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [ENT_W-1:0] push_ent,
    input  logic             pop,
    output logic             head_valid,
    output logic [ENT_W-1:0] head_ent
);

    logic [ENT_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [LVL_W-1:0] level;
    logic             do_push;
    logic             do_pop;

    assign head_valid = (level != '0);
    assign head_ent   = mem[rd_ptr];
    assign do_pop     = pop && head_valid;
    assign do_push    = push && (level != LVL_W'(DEPTH));

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_ent;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

endmodule

// File: rtl/srcshare_inport.sv
module srcshare_inport
    import srcshare_pkg::*;
#(
    parameter int  NUM_SRC = 4,
    parameter int  SLOTS   = 2,
    parameter int  DATA_W  = 8,
    localparam int SRC_W   = idx_width(NUM_SRC)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [SRC_W-1:0]  in_src,
    input  logic              in_cls,
    input  logic [DATA_W-1:0] in_data,
    output logic              nack_valid,
    output logic [SRC_W-1:0]  nack_src,
    input  logic              req_pop,
    output logic              req_valid,
    output logic [SRC_W-1:0]  req_src,
    output logic [DATA_W-1:0] req_data,
    input  logic              rsp_pop,
    output logic              rsp_valid,
    output logic [SRC_W-1:0]  rsp_src,
    output logic [DATA_W-1:0] rsp_data
);

    localparam int CNT_W   = count_width(SLOTS);
    localparam int DEPTH   = NUM_SRC * SLOTS;
    localparam int ENT_W   = SRC_W + DATA_W;
    localparam int PTR_W   = idx_width(DEPTH);
    localparam int LVL_W   = count_width(DEPTH);
    localparam int LEDG_W  = NUM_SRC * CNT_W;

    logic                             cls_pop   [NUM_CLASSES];
    logic                             cls_valid [NUM_CLASSES];
    logic [ENT_W-1:0]                 cls_head  [NUM_CLASSES];
    logic [NUM_CLASSES-1:0]           accept_vec;
    logic [NUM_CLASSES*LEDG_W-1:0]    occ_all;
    logic [ENT_W-1:0]                 in_ent;

    assign in_ent     = {in_src, in_data};
    assign cls_pop[0] = req_pop;
    assign cls_pop[1] = rsp_pop;

    for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cls
        logic             try_wr;
        logic             pop_fire;
        logic [SRC_W-1:0] pop_src;

        assign try_wr   = in_valid && (in_cls == 1'(c));
        assign pop_fire = cls_pop[c] && cls_valid[c];
        assign pop_src  = cls_head[c][ENT_W-1 -: SRC_W];

        srcshare_ledger #(
            .NUM_SRC (NUM_SRC),
            .SLOTS   (SLOTS),
            .SRC_W   (SRC_W),
            .CNT_W   (CNT_W)
        ) u_ledger (
            .clk      (clk),
            .rst      (rst),
            .try_wr   (try_wr),
            .wr_src   (in_src),
            .pop_fire (pop_fire),
            .pop_src  (pop_src),
            .accept   (accept_vec[c]),
            .occ_flat (occ_all[c*LEDG_W +: LEDG_W])
        );

        srcshare_fifo #(
            .DEPTH (DEPTH),
            .ENT_W (ENT_W),
            .PTR_W (PTR_W),
            .LVL_W (LVL_W)
        ) u_queue (
            .clk        (clk),
            .rst        (rst),
            .push       (accept_vec[c]),
            .push_ent   (in_ent),
            .pop        (cls_pop[c]),
            .head_valid (cls_valid[c]),
            .head_ent   (cls_head[c])
        );
    end

    assign req_valid = cls_valid[CLS_REQ];
    assign req_src   = cls_head[CLS_REQ][ENT_W-1 -: SRC_W];
    assign req_data  = cls_head[CLS_REQ][DATA_W-1:0];
    assign rsp_valid = cls_valid[CLS_RSP];
    assign rsp_src   = cls_head[CLS_RSP][ENT_W-1 -: SRC_W];
    assign rsp_data  = cls_head[CLS_RSP][DATA_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            nack_valid <= 1'b0;
            nack_src   <= '0;
        end else begin
            nack_valid <= in_valid && !(|accept_vec);
            nack_src   <= in_src;
        end
    end

endmodule

// File: rtl/srcshare_checker.sv
module srcshare_checker #(
    parameter int NUM_SRC = 4,
    parameter int SLOTS   = 2,
    parameter int SRC_W   = 2,
    parameter int DATA_W  = 8,
    parameter int CNT_W   = 2
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       in_valid,
    input logic [SRC_W-1:0]           in_src,
    input logic                       in_cls,
    input logic                       nack_valid,
    input logic [SRC_W-1:0]           nack_src,
    input logic                       req_pop,
    input logic                       req_valid,
    input logic [SRC_W-1:0]           req_src,
    input logic [DATA_W-1:0]          req_data,
    input logic                       rsp_pop,
    input logic                       rsp_valid,
    input logic [SRC_W-1:0]           rsp_src,
    input logic [DATA_W-1:0]          rsp_data,
    input logic [2*NUM_SRC*CNT_W-1:0] occ_all
);

    logic [CNT_W-1:0] sel_occ;
    assign sel_occ = occ_all[(int'(in_cls)*NUM_SRC + int'(in_src))*CNT_W +: CNT_W];

    // R4: a refusal only follows an arriving packet, and names its source
    p_nack_follows_input_r4: assert property (@(posedge clk) disable iff (rst)
        nack_valid |-> $past(in_valid));
    p_nack_names_source_r4: assert property (@(posedge clk) disable iff (rst)
        nack_valid |-> (nack_src == $past(in_src)));

    // R5 / R6: a packet whose own share has room is never refused
    p_room_means_accept_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (sel_occ < CNT_W'(SLOTS))) |=> !nack_valid);

    // R3: occupancy never exceeds the reserved share
    for (genvar k = 0; k < 2*NUM_SRC; k++) begin : g_lim
        p_share_bound_r3: assert property (@(posedge clk) disable iff (rst)
            occ_all[k*CNT_W +: CNT_W] <= CNT_W'(SLOTS));
    end

    // R7: heads hold while not popped
    p_req_head_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_pop) |=> (req_valid && $stable(req_src) && $stable(req_data)));
    p_rsp_head_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_pop) |=> (rsp_valid && $stable(rsp_src) && $stable(rsp_data)));

    // R11: popping an empty queue with nothing arriving leaves it empty
    p_req_empty_pop_r11: assert property (@(posedge clk) disable iff (rst)
        (!req_valid && req_pop && !in_valid) |=> !req_valid);
    p_rsp_empty_pop_r11: assert property (@(posedge clk) disable iff (rst)
        (!rsp_valid && rsp_pop && !in_valid) |=> !rsp_valid);

endmodule

bind srcshare_inport srcshare_checker #(
    .NUM_SRC (NUM_SRC),
    .SLOTS   (SLOTS),
    .SRC_W   (SRC_W),
    .DATA_W  (DATA_W),
    .CNT_W   (CNT_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_src     (in_src),
    .in_cls     (in_cls),
    .nack_valid (nack_valid),
    .nack_src   (nack_src),
    .req_pop    (req_pop),
    .req_valid  (req_valid),
    .req_src    (req_src),
    .req_data   (req_data),
    .rsp_pop    (rsp_pop),
    .rsp_valid  (rsp_valid),
    .rsp_src    (rsp_src),
    .rsp_data   (rsp_data),
    .occ_all    (occ_all)
);

// File: tb/srcshare_inport_test.sv
module srcshare_inport_test;
    import srcshare_pkg::*;

    localparam int NUM_SRC = 4;
    localparam int SLOTS   = 2;
    localparam int DATA_W  = 8;
    localparam int SRC_W   = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [SRC_W-1:0]  in_src = '0;
    logic              in_cls = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic              nack_valid;
    logic [SRC_W-1:0]  nack_src;
    logic              req_pop = 1'b0;
    logic              req_valid;
    logic [SRC_W-1:0]  req_src;
    logic [DATA_W-1:0] req_data;
    logic              rsp_pop = 1'b0;
    logic              rsp_valid;
    logic [SRC_W-1:0]  rsp_src;
    logic [DATA_W-1:0] rsp_data;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    srcshare_inport #(
        .NUM_SRC (NUM_SRC),
        .SLOTS   (SLOTS),
        .DATA_W  (DATA_W)
    ) uut (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_src     (in_src),
        .in_cls     (in_cls),
        .in_data    (in_data),
        .nack_valid (nack_valid),
        .nack_src   (nack_src),
        .req_pop    (req_pop),
        .req_valid  (req_valid),
        .req_src    (req_src),
        .req_data   (req_data),
        .rsp_pop    (rsp_pop),
        .rsp_valid  (rsp_valid),
        .rsp_src    (rsp_src),
        .rsp_data   (rsp_data)
    );

    task automatic chk(input string rq, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    // One clock: inputs applied at a falling edge, cleared at the next one.
    task automatic cyc(input logic v, input int src, input logic cls, input int data,
                       input logic rp, input logic sp);
        in_valid = v;
        in_src   = SRC_W'(src);
        in_cls   = cls;
        in_data  = DATA_W'(data);
        req_pop  = rp;
        rsp_pop  = sp;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        req_pop  = 1'b0;
        rsp_pop  = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "req_valid", int'(req_valid), 0);
        chk("R1", "rsp_valid", int'(rsp_valid), 0);
        chk("R1", "nack_valid", int'(nack_valid), 0);
    endtask

    task automatic t_accept_basic();
        cyc(1, 1, CLS_REQ, 'hA5, 0, 0);
        chk("R4", "no nack on accept", int'(nack_valid), 0);
        chk("R2", "req_valid", int'(req_valid), 1);
        chk("R2", "req_src", int'(req_src), 1);
        chk("R2", "req_data", int'(req_data), 'hA5);
        chk("R2", "rsp untouched", int'(rsp_valid), 0);
        cyc(1, 3, CLS_RSP, 'h5A, 0, 0);
        chk("R2", "rsp_valid", int'(rsp_valid), 1);
        chk("R2", "rsp_src", int'(rsp_src), 3);
        chk("R2", "rsp_data", int'(rsp_data), 'h5A);
        cyc(0, 0, CLS_REQ, 0, 1, 1);
        chk("R2", "req drained", int'(req_valid), 0);
        chk("R2", "rsp drained", int'(rsp_valid), 0);
    endtask

    task automatic t_share_limit();
        cyc(1, 2, CLS_REQ, 'h11, 0, 0);
        cyc(1, 2, CLS_REQ, 'h22, 0, 0);
        chk("R3", "second accepted", int'(nack_valid), 0);
        cyc(1, 2, CLS_REQ, 'h33, 0, 0);
        chk("R4", "nack on third", int'(nack_valid), 1);
        chk("R4", "nack_src", int'(nack_src), 2);
        cyc(0, 0, CLS_REQ, 0, 0, 0);
        chk("R4", "nack one cycle", int'(nack_valid), 0);
        chk("R7", "head first", int'(req_data), 'h11);
        cyc(0, 0, CLS_REQ, 0, 1, 0);
        chk("R7", "head second", int'(req_data), 'h22);
        cyc(0, 0, CLS_REQ, 0, 1, 0);
        chk("R3", "refused not stored", int'(req_valid), 0);
    endtask

    task automatic t_other_sources();
        cyc(1, 2, CLS_REQ, 'h41, 0, 0);
        cyc(1, 2, CLS_REQ, 'h42, 0, 0);
        cyc(1, 3, CLS_REQ, 'h43, 0, 0);
        chk("R5", "other source accepted", int'(nack_valid), 0);
        cyc(1, 2, CLS_RSP, 'h44, 0, 0);
        chk("R6", "response accepted", int'(nack_valid), 0);
        chk("R6", "rsp_valid", int'(rsp_valid), 1);
        chk("R6", "rsp_src", int'(rsp_src), 2);
        chk("R6", "rsp_data", int'(rsp_data), 'h44);
        cyc(0, 0, CLS_REQ, 0, 0, 1);
        chk("R6", "rsp drains", int'(rsp_valid), 0);
        chk("R6", "req held", int'(req_valid), 1);
        cyc(1, 2, CLS_RSP, 'h45, 0, 0);
        chk("R6", "second response", int'(nack_valid), 0);
        chk("R6", "rsp_data 2", int'(rsp_data), 'h45);
        cyc(0, 0, CLS_REQ, 0, 0, 1);
        chk("R7", "order 1", int'(req_data), 'h41);
        cyc(0, 0, CLS_REQ, 0, 1, 0);
        chk("R7", "order 2", int'(req_data), 'h42);
        cyc(0, 0, CLS_REQ, 0, 1, 0);
        chk("R7", "order 3 data", int'(req_data), 'h43);
        chk("R7", "order 3 src", int'(req_src), 3);
        cyc(0, 0, CLS_REQ, 0, 1, 0);
        chk("R7", "drained", int'(req_valid), 0);
    endtask

    task automatic t_pop_frees();
        cyc(1, 0, CLS_REQ, 'h51, 0, 0);
        cyc(1, 0, CLS_REQ, 'h52, 0, 0);
        cyc(1, 0, CLS_REQ, 'h53, 0, 0);
        chk("R8", "full refused", int'(nack_valid), 1);
        cyc(0, 0, CLS_REQ, 0, 1, 0);
        chk("R8", "head after pop", int'(req_data), 'h52);
        cyc(1, 0, CLS_REQ, 'h54, 0, 0);
        chk("R8", "freed slot used", int'(nack_valid), 0);
        cyc(0, 0, CLS_REQ, 0, 1, 0);
        chk("R8", "new packet queued", int'(req_data), 'h54);
        cyc(0, 0, CLS_REQ, 0, 1, 0);
        chk("R8", "drained", int'(req_valid), 0);
    endtask

    task automatic t_start_of_cycle();
        cyc(1, 1, CLS_REQ, 'h61, 0, 0);
        cyc(1, 1, CLS_REQ, 'h62, 0, 0);
        cyc(1, 1, CLS_REQ, 'h63, 1, 0);
        chk("R10", "refused despite pop", int'(nack_valid), 1);
        chk("R10", "nack_src", int'(nack_src), 1);
        chk("R10", "head", int'(req_data), 'h62);
        cyc(0, 0, CLS_REQ, 0, 1, 0);
        chk("R10", "not stored", int'(req_valid), 0);
    endtask

    task automatic t_same_cycle();
        cyc(1, 3, CLS_REQ, 'h71, 0, 0);
        cyc(1, 3, CLS_REQ, 'h72, 1, 0);
        chk("R9", "accepted with pop", int'(nack_valid), 0);
        chk("R9", "head", int'(req_data), 'h72);
        cyc(1, 3, CLS_REQ, 'h73, 0, 0);
        chk("R9", "one slot left", int'(nack_valid), 0);
        cyc(1, 3, CLS_REQ, 'h74, 0, 0);
        chk("R9", "share full again", int'(nack_valid), 1);
        cyc(0, 0, CLS_REQ, 0, 1, 0);
        chk("R9", "next head", int'(req_data), 'h73);
        cyc(0, 0, CLS_REQ, 0, 1, 0);
        chk("R9", "drained", int'(req_valid), 0);
    endtask

    task automatic t_empty_pop();
        cyc(0, 0, CLS_REQ, 0, 1, 1);
        chk("R11", "req stays empty", int'(req_valid), 0);
        chk("R11", "rsp stays empty", int'(rsp_valid), 0);
        chk("R11", "no nack", int'(nack_valid), 0);
        cyc(1, 1, CLS_RSP, 'h81, 0, 0);
        chk("R11", "first accepted", int'(nack_valid), 0);
        cyc(1, 1, CLS_RSP, 'h82, 0, 0);
        chk("R11", "second accepted", int'(nack_valid), 0);
        cyc(1, 1, CLS_RSP, 'h83, 0, 0);
        chk("R11", "third refused", int'(nack_valid), 1);
        chk("R11", "head", int'(rsp_data), 'h81);
        cyc(0, 0, CLS_REQ, 0, 0, 1);
        chk("R11", "next head", int'(rsp_data), 'h82);
        cyc(0, 0, CLS_REQ, 0, 0, 1);
        chk("R11", "drained", int'(rsp_valid), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_accept_basic();
        t_share_limit();
        t_other_sources();
        t_pop_frees();
        t_start_of_cycle();
        t_same_cycle();
        t_empty_pop();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog (all): actual=timeout expected=completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule